// File: doc/BRIEF.md
# OSD Dot Size Timing Generator

This block times the dots of one character-display block of an on-screen display. It forms a base dot tick from one of two source clocks. The source clocks are given as clock-enable pulses in the system clock domain. The selected source passes through a pre-divider that divides by 1, 2 or 3, and one pre-divider output period is the base tick (TC). Each dot is then stretched horizontally by counting TC ticks and vertically by counting HSYNC pulses.

After each HSYNC rising edge the block counts four source enables for every unit of the programmed horizontal position. When that count completes, it waits exactly one further TC and then emits the first dot. Because of this gap, blocks with different pre-divide ratios or sources start at different horizontal points.

The outputs are a dot-advance strobe, a line-advance strobe and a display-active flag for the downstream pixel logic. Vertical counting starts on a block-start pulse and stops on the VSYNC rising edge. A caption-mode block that asks for a pre-divide ratio of 3 is flagged and runs at ratio 2. All register fields are sampled only on an HSYNC edge, so a line is never split.

Top module: `osd_dot_timer`

## Requirements
- R1: While reset is low and after its release, before any HSYNC, dot_adv_o, line_adv_o, active_o and ratio_err_o are low.
- R2: src_sel_i = 0 takes the slicer enable and src_sel_i = 1 takes the oscillator enable. Pulses on the enable that is not selected have no effect on dot_adv_o.
- R3: The ratio field encodes 2'b00 and 2'b01 as divide-by-1, 2'b10 as divide-by-2 and 2'b11 as divide-by-3. One TC is that many selected source enables.
- R4: Number clock edges from the first edge that samples hsync_i high as edge 0, with the source enable high on every cycle, a position value N ≥ 1 and an effective ratio R. The first dot_adv_o pulse is then visible after edge 2+4N+R. This is 4N source enables from the internal HSYNC edge plus exactly one TC.
- R5: After the first dot, dot_adv_o pulses once every (H+1)·R cycles, where H is the 2-bit horizontal size field (1 to 4 TC per dot).
- R6: With cc_mode_i = 1 and ratio 2'b11, the block runs at divide-by-2 and ratio_err_o is high. ratio_err_o returns low at the first HSYNC that latches a legal setting.
- R7: After blk_start_i, line_adv_o pulses once every V+1 HSYNC edges, where V is the 2-bit vertical size field.
- R8: With biscan_i = 1, the line count per dot row is doubled to 2·(V+1).
- R9: Register field changes between HSYNC edges do not alter the dot timing of the current line. They take effect from the next HSYNC edge.
- R10: A VSYNC rising edge disables the block. active_o, dot_adv_o and line_adv_o then stay low until the next blk_start_i pulse.
- R11: active_o rises together with the first dot_adv_o pulse of a line. It is low after edge 2 of the next HSYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slicer_ce_i | input | 1 | Slicer source clock enable |
| osc_ce_i | input | 1 | Oscillator source clock enable |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| blk_start_i | input | 1 | One-cycle pulse that starts the block's rows |
| src_sel_i | input | 1 | Source select: 0 slicer, 1 oscillator |
| ratio_i | input | 2 | Pre-divide ratio field |
| cc_mode_i | input | 1 | Caption mode |
| hsize_i | input | HSZ_W | TC per dot minus one |
| vsize_i | input | VSZ_W | Lines per dot minus one |
| biscan_i | input | 1 | Bi-scan: double dot height |
| hpos_i | input | HPOS_W | Horizontal start position N |
| dot_adv_o | output | 1 | Start of each dot |
| line_adv_o | output | 1 | End of each dot row |
| active_o | output | 1 | Dots are being emitted on this line |
| ratio_err_o | output | 1 | Illegal ratio for caption mode was latched |

## Verification
The assertions assume that the effective ratio and the size fields change only at an HSYNC edge. They also assume that HSYNC pulses last longer than the two-flop synchronizer, so each pulse gives exactly one internal edge. The stimulus changes register fields only while the bench is between lines, with one exception: the mid-line change that tests R9. HSYNC is held high for four cycles and VSYNC for several cycles. blk_start_i is driven as a single-cycle synchronous pulse, never in the same cycle as an internal HSYNC edge.

// File: rtl/osd_dot_pkg.sv
package osd_dot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_GAP,
    PH_DOTS
  } hphase_e;

  // caption mode forbids /3: fall back to /2
  function automatic logic [1:0] eff_ratio(input logic [1:0] fld, input logic cc);
    case (fld)
      2'b11:   eff_ratio = cc ? 2'd2 : 2'd3;
      2'b10:   eff_ratio = 2'd2;
      default: eff_ratio = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/osd_hdot_gen.sv
module osd_hdot_gen
  import osd_dot_pkg::*;
#(
  parameter int HPOS_W = 6,
  parameter int HSZ_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_ce_i,
  input  logic              line_start_i,
  input  logic              en_i,
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic [1:0]        ratio_i,
  input  logic [HSZ_W-1:0]  hsize_i,
  output logic              dot_adv_o,
  output logic              active_o
);
  localparam int POS_W = HPOS_W + 2;

  hphase_e           phase_q;
  logic [POS_W-1:0]  pos_cnt_q;
  logic [1:0]        pdiv_q;
  logic [HSZ_W-1:0]  dot_cnt_q;
  logic              tc;
  logic              pos_done;
  logic              dot_edge;

  // predivider runs only once start count is done, so the gap is exactly one TC
  assign tc       = src_ce_i && (phase_q == PH_GAP || phase_q == PH_DOTS)
                    && (pdiv_q == ratio_i - 2'd1);
  assign pos_done = (hpos_i == '0) ||
                    (src_ce_i && pos_cnt_q == ({hpos_i, 2'b00} - POS_W'(1)));
  assign dot_edge = tc && (phase_q == PH_GAP ||
                           (phase_q == PH_DOTS && dot_cnt_q == hsize_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      pos_cnt_q <= '0;
      pdiv_q    <= '0;
      dot_cnt_q <= '0;
      dot_adv_o <= 1'b0;
      active_o  <= 1'b0;
    end else if (line_start_i) begin
      phase_q   <= PH_START;
      pos_cnt_q <= '0;
      pdiv_q    <= '0;
      dot_cnt_q <= '0;
      dot_adv_o <= 1'b0;
      active_o  <= 1'b0;
    end else begin
      dot_adv_o <= en_i && dot_edge;
      active_o  <= en_i && (phase_q == PH_DOTS || (phase_q == PH_GAP && tc));
      case (phase_q)
        PH_START: begin
          if (pos_done) phase_q <= PH_GAP;
          else if (src_ce_i) pos_cnt_q <= pos_cnt_q + POS_W'(1);
        end
        PH_GAP, PH_DOTS: begin
          if (src_ce_i) pdiv_q <= tc ? 2'd0 : pdiv_q + 2'd1;
          if (tc) begin
            if (phase_q == PH_GAP || dot_cnt_q == hsize_i) dot_cnt_q <= '0;
            else dot_cnt_q <= dot_cnt_q + HSZ_W'(1);
            phase_q <= PH_DOTS;
          end
        end
        default: ;
      endcase
    end
  end

  p_pdiv_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP || phase_q == PH_DOTS) |-> pdiv_q < ratio_i);

  p_no_dot_before_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_START || phase_q == PH_IDLE) |=> !dot_adv_o);

  p_dot_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_DOTS |-> dot_cnt_q <= hsize_i);

  p_line_start_resets_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (phase_q == PH_START && !active_o && !dot_adv_o));

  p_active_with_dot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> dot_adv_o);

endmodule

// File: rtl/osd_vdot_gen.sv
module osd_vdot_gen #(
  parameter int VSZ_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             frame_i,
  input  logic             blk_start_i,
  input  logic [VSZ_W-1:0] vsize_i,
  input  logic             biscan_i,
  output logic             line_adv_o,
  output logic             en_o
);
  localparam int LIM_W = VSZ_W + 2;
  localparam int CNT_W = VSZ_W + 1;

  logic [LIM_W-1:0] lines;
  logic [CNT_W-1:0] lim_m1;
  logic [CNT_W-1:0] cnt_q;

  assign lines  = (LIM_W'(vsize_i) + LIM_W'(1)) << biscan_i;
  assign lim_m1 = CNT_W'(lines - LIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      cnt_q      <= '0;
      line_adv_o <= 1'b0;
    end else begin
      line_adv_o <= 1'b0;
      if (blk_start_i) begin
        en_o  <= 1'b1;
        cnt_q <= '0;
      end else begin
        if (frame_i) en_o <= 1'b0;
        if (line_i && en_o) begin
          if (cnt_q >= lim_m1) begin
            cnt_q      <= '0;
            line_adv_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  p_start_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_i |=> (en_o && cnt_q == '0));

  p_adv_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_adv_o |-> $past(en_o));

  p_frame_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !blk_start_i) |=> !en_o);

endmodule

// File: rtl/osd_dot_timer.sv
module osd_dot_timer
  import osd_dot_pkg::*;
#(
  parameter int HPOS_W = 6,
  parameter int HSZ_W  = 2,
  parameter int VSZ_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slicer_ce_i,
  input  logic              osc_ce_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              blk_start_i,
  input  logic              src_sel_i,
  input  logic [1:0]        ratio_i,
  input  logic              cc_mode_i,
  input  logic [HSZ_W-1:0]  hsize_i,
  input  logic [VSZ_W-1:0]  vsize_i,
  input  logic              biscan_i,
  input  logic [HPOS_W-1:0] hpos_i,
  output logic              dot_adv_o,
  output logic              line_adv_o,
  output logic              active_o,
  output logic              ratio_err_o
);
  logic              hs_rise, vs_rise;
  logic              src_q, biscan_q;
  logic [1:0]        ratio_q;
  logic [HSZ_W-1:0]  hsize_q;
  logic [VSZ_W-1:0]  vsize_q;
  logic [HPOS_W-1:0] hpos_q;
  logic              src_ce;
  logic              blk_en;

  osd_sync_edge #(.STAGES(2)) u_hs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hsync_i), .rise_o(hs_rise));

  osd_sync_edge #(.STAGES(2)) u_vs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vsync_i), .rise_o(vs_rise));

  // shadow fields: sampled only at HSYNC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q       <= 1'b0;
      ratio_q     <= 2'd1;
      ratio_err_o <= 1'b0;
      hsize_q     <= '0;
      vsize_q     <= '0;
      biscan_q    <= 1'b0;
      hpos_q      <= '0;
    end else if (hs_rise) begin
      src_q       <= src_sel_i;
      ratio_q     <= eff_ratio(ratio_i, cc_mode_i);
      ratio_err_o <= cc_mode_i && (ratio_i == 2'b11);
      hsize_q     <= hsize_i;
      vsize_q     <= vsize_i;
      biscan_q    <= biscan_i;
      hpos_q      <= hpos_i;
    end
  end

  assign src_ce = src_q ? osc_ce_i : slicer_ce_i;

  osd_hdot_gen #(.HPOS_W(HPOS_W), .HSZ_W(HSZ_W)) u_hdot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_ce_i    (src_ce),
    .line_start_i(hs_rise),
    .en_i        (blk_en),
    .hpos_i      (hpos_q),
    .ratio_i     (ratio_q),
    .hsize_i     (hsize_q),
    .dot_adv_o   (dot_adv_o),
    .active_o    (active_o)
  );

  osd_vdot_gen #(.VSZ_W(VSZ_W)) u_vdot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (hs_rise),
    .frame_i    (vs_rise),
    .blk_start_i(blk_start_i),
    .vsize_i    (vsize_q),
    .biscan_i   (biscan_q),
    .line_adv_o (line_adv_o),
    .en_o       (blk_en)
  );

  p_cc_fallback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_o |-> ratio_q == 2'd2);

  p_fields_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hs_rise) |-> ($stable(ratio_q) && $stable(hsize_q) && $stable(hpos_q)));

  p_dot_implies_active_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_adv_o |-> active_o);

endmodule

// File: tb/osd_dot_timer_bench.sv
module osd_dot_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slicer_ce_i = 1'b0, osc_ce_i = 1'b1;
  logic       hsync_i = 1'b0, vsync_i = 1'b0, blk_start_i = 1'b0;
  logic       src_sel_i = 1'b1, cc_mode_i = 1'b0, biscan_i = 1'b0;
  logic [1:0] ratio_i = 2'b01, hsize_i = 2'd0, vsize_i = 2'd0;
  logic [5:0] hpos_i = 6'd3;
  logic       dot_adv_o, line_adv_o, active_o, ratio_err_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  osd_dot_timer u_osd_dot_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .slicer_ce_i(slicer_ce_i), .osc_ce_i(osc_ce_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .blk_start_i(blk_start_i),
    .src_sel_i(src_sel_i), .ratio_i(ratio_i), .cc_mode_i(cc_mode_i),
    .hsize_i(hsize_i), .vsize_i(vsize_i), .biscan_i(biscan_i), .hpos_i(hpos_i),
    .dot_adv_o(dot_adv_o), .line_adv_o(line_adv_o), .active_o(active_o),
    .ratio_err_o(ratio_err_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one HSYNC, then observe m cycles; k = index of the edge since hsync seen high
  int first, second, ndots, nlines, act_first, act_early;
  task automatic do_line(input int m, input int chg_k);
    first = -1; second = -1; ndots = 0; nlines = 0; act_first = 0; act_early = 1;
    @(negedge clk_i); hsync_i = 1'b1;
    for (int k = 0; k < m; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (k == 3) hsync_i = 1'b0;
      if (k == chg_k) begin hsize_i = 2'd3; ratio_i = 2'b11; hpos_i = 6'd9; end
      if (k == 2) act_early = active_o;
      if (line_adv_o) nlines++;
      if (k >= 2 && dot_adv_o) begin
        ndots++;
        if (first < 0) begin first = k; act_first = active_o; end
        else if (second < 0) second = k;
      end
    end
  endtask

  task automatic blk_start();
    @(negedge clk_i); blk_start_i = 1'b1;
    @(negedge clk_i); blk_start_i = 1'b0;
  endtask

  task automatic set_regs(input bit src, input logic [1:0] rat, input bit cc,
                          input logic [1:0] hs, input int n);
    src_sel_i = src; ratio_i = rat; cc_mode_i = cc; hsize_i = hs; hpos_i = 6'(n);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(dot_adv_o == 0 && line_adv_o == 0, "R1 strobes in reset", int'(dot_adv_o | line_adv_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(active_o == 0, "R1 active after reset", int'(active_o), 0);
    chk(ratio_err_o == 0, "R1 ratio_err after reset", int'(ratio_err_o), 0);
    chk(dot_adv_o == 0, "R1 no dot before hsync", int'(dot_adv_o), 0);
  endtask

  task automatic t_hpos_div1();
    set_regs(1'b1, 2'b01, 1'b0, 2'd0, 3);
    do_line(40, -1);
    chk(first == 2 + 12 + 1, "R4 first dot N=3 R=1", first, 15);
    chk(second - first == 1, "R5 width H=0 R=1", second - first, 1);
    chk(act_first == 1, "R11 active with first dot", act_first, 1);
    chk(act_early == 0, "R11 active low after hsync", act_early, 0);
  endtask

  task automatic t_div2();
    set_regs(1'b1, 2'b10, 1'b0, 2'd2, 2);
    do_line(60, -1);
    chk(first == 2 + 8 + 2, "R3 first dot R=2", first, 12);
    chk(second - first == 6, "R5 width H=2 R=2", second - first, 6);
  endtask

  task automatic t_div3();
    set_regs(1'b1, 2'b11, 1'b0, 2'd3, 1);
    do_line(80, -1);
    chk(first == 2 + 4 + 3, "R3 first dot R=3", first, 9);
    chk(second - first == 12, "R5 width H=3 R=3", second - first, 12);
    chk(ratio_err_o == 0, "R6 no flag outside caption", int'(ratio_err_o), 0);
  endtask

  task automatic t_cc();
    set_regs(1'b1, 2'b11, 1'b1, 2'd1, 1);
    do_line(60, -1);
    chk(first == 2 + 4 + 2, "R6 caption fallback first dot", first, 8);
    chk(second - first == 4, "R6 caption fallback width", second - first, 4);
    chk(ratio_err_o == 1, "R6 flag set", int'(ratio_err_o), 1);
    set_regs(1'b1, 2'b10, 1'b1, 2'd1, 1);
    do_line(30, -1);
    chk(ratio_err_o == 0, "R6 flag cleared by legal ratio", int'(ratio_err_o), 0);
  endtask

  task automatic t_src();
    set_regs(1'b0, 2'b01, 1'b0, 2'd0, 2);
    slicer_ce_i = 1'b0; osc_ce_i = 1'b1;
    do_line(100, -1);
    chk(ndots == 0, "R2 unselected oscillator ignored", ndots, 0);
    slicer_ce_i = 1'b1; osc_ce_i = 1'b0;
    do_line(40, -1);
    chk(first == 2 + 8 + 1, "R2 slicer source timing", first, 11);
    set_regs(1'b1, 2'b01, 1'b0, 2'd0, 2);
    do_line(100, -1);
    chk(ndots == 0, "R2 unselected slicer ignored", ndots, 0);
    slicer_ce_i = 1'b0; osc_ce_i = 1'b1;
  endtask

  task automatic t_midline();
    set_regs(1'b1, 2'b01, 1'b0, 2'd0, 2);
    do_line(40, 5);
    chk(first == 11, "R9 first dot unchanged", first, 11);
    chk(second - first == 1, "R9 width unchanged mid-line", second - first, 1);
    do_line(100, -1);
    chk(first == 2 + 36 + 3, "R9 new fields at next hsync", first, 41);
    chk(second - first == 12, "R9 new width at next hsync", second - first, 12);
  endtask

  task automatic t_vert(input logic [1:0] v, input bit bi, input int nhs,
                        input int exp, input string req);
    int tot;
    vsize_i = v; biscan_i = bi;
    do_line(10, -1);
    blk_start();
    tot = 0;
    for (int i = 0; i < nhs; i++) begin
      do_line(10, -1);
      tot += nlines;
    end
    chk(tot == exp, req, tot, exp);
  endtask

  task automatic t_vsync();
    int tot;
    set_regs(1'b1, 2'b01, 1'b0, 2'd0, 1);
    vsize_i = 2'd0; biscan_i = 1'b0;
    @(negedge clk_i); vsync_i = 1'b1;
    repeat (5) @(negedge clk_i); vsync_i = 1'b0;
    repeat (3) @(negedge clk_i);
    tot = 0;
    do_line(40, -1); tot += nlines;
    chk(ndots == 0, "R10 no dots after vsync", ndots, 0);
    chk(act_first == 0 && active_o == 0, "R10 active low after vsync", int'(active_o), 0);
    do_line(20, -1); tot += nlines;
    chk(tot == 0, "R10 no line_adv after vsync", tot, 0);
    blk_start();
    do_line(40, -1);
    chk(first == 2 + 4 + 1, "R10 block start resumes dots", first, 7);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    do_line(20, -1);
    blk_start();
    t_hpos_div1();
    t_div2();
    t_div3();
    t_cc();
    t_src();
    t_midline();
    t_vert(2'd2, 1'b0, 12, 4, "R7 V=2 line_adv count");
    t_vert(2'd0, 1'b0, 5, 5, "R7 V=0 line_adv count");
    t_vert(2'd2, 1'b1, 12, 2, "R8 bi-scan V=2 count");
    t_vert(2'd0, 1'b1, 6, 3, "R8 bi-scan V=0 count");
    t_vsync();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule